// File: doc/BRIEF.md
# Interleaved Video Memory Address Generator

This block turns a display position into the memory address of the byte a bitmap video engine must fetch next. The screen is 256x192 one-bit pixels with a colour byte per 8x8 cell. The scan logic supplies the current display line, the byte column and a fetch kind (pixel byte or colour byte). The block returns a 16-bit address, a fetch strobe and an out-of-range flag.

Pixel rows are not stored in display order. The line number is split into a screen third, a cell row and a line within the cell, and these fields are reordered to form the offset. A 3-bit mode field selects one of four layouts:
- the standard layout;
- a second screen buffer 0x2000 higher;
- per-line colour, where colour bytes use the same interleaved layout as pixels;
- a 512-pixel-wide layout, where successive byte columns come from the two buffers in turn.

The address path is combinational. A parameter can place one register stage at the output.

Top module: `vid_addr_gen`

## Requirements
- R1: For a pixel fetch in mode 3'b000, the address is 0x4000 + third*2048 + sub*256 + row*32 + c, where third = line/64, row = (line/8)%8, sub = line%8 and c = col_i[4:0]. col_i[5] has no effect in this mode.
- R2: For a colour fetch in mode 3'b000, the address is 0x5800 + (line/8)*32 + col_i[4:0].
- R3: Mode 3'b001 adds 0x2000 to both the pixel address and the colour address. This gives a pixel base of 0x6000 and a colour table at 0x7800.
- R4: In mode 3'b010, pixel addresses are the same as in R1. Colour addresses are 0x6000 plus the same interleaved offset that R1 uses for pixels.
- R5: In mode 3'b110, col_i[0] selects the buffer (0 gives 0x4000, 1 gives 0x6000) and col_i[5:1] is the byte offset within the line. The line fields are used as in R1.
- R6: In mode 3'b110, a colour fetch request (kind_i=1) leaves fetch_o low.
- R7: A line input of 192 or more raises oor_o and forces fetch_o low. A line below 192 keeps oor_o low.
- R8: The unlisted mode codes 3'b011, 3'b100, 3'b101 and 3'b111 give exactly the addresses of mode 3'b000.
- R9: fetch_o equals req_i unless R6 or R7 suppresses it. A low req_i always gives a low fetch_o.
- R10: With REG_OUT=1, every output shows the result for the inputs present at the previous rising clock edge. While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| line_i | input | 8 | Display line, 0 to 191 valid |
| col_i | input | 6 | Byte column; bits 4:0 normally, bits 5:0 in wide mode |
| mode_i | input | 3 | Layout mode code |
| kind_i | input | 1 | 0 = pixel byte, 1 = colour byte |
| req_i | input | 1 | Fetch request |
| addr_o | output | 16 | Fetch address |
| fetch_o | output | 1 | Fetch strobe |
| oor_o | output | 1 | Line out of range |

## Verification
The assertions assume that line, column, mode, kind and request inputs are stable from one rising edge to the next. With the output register, they also assume each input set is held for a full cycle so that the registered result can be matched against the previous cycle's inputs. The stimulus changes inputs only between edges. It sweeps every line up to 199, every 6-bit column, all eight mode codes and both fetch kinds. Requests are switched off on some vectors, so the strobe gating is exercised alongside the address arithmetic.

// File: rtl/vid_addr_pkg.sv
package vid_addr_pkg;

   typedef enum logic [1:0] {
      LAY_STD     = 2'd0,
      LAY_ALT     = 2'd1,
      LAY_LINECLR = 2'd2,
      LAY_WIDE    = 2'd3
   } layout_e;

   localparam logic [15:0] BUF_LO_BASE = 16'h4000;
   localparam logic [15:0] BUF_HI_BASE = 16'h6000;
   localparam logic [15:0] CLR_TBL_OFF = 16'h1800;

   typedef struct packed {
      logic [1:0] third;
      logic [2:0] row;
      logic [2:0] sub;
   } line_fields_t;

endpackage

// File: rtl/vid_mode_dec.sv
module vid_mode_dec
   import vid_addr_pkg::*;
#(
   parameter int MODE_W = 3
) (
   input  logic [MODE_W-1:0] mode_i,
   output layout_e           layout_o
);
   always_comb begin
      unique case (mode_i[2:0])
         3'b001:  layout_o = LAY_ALT;
         3'b010:  layout_o = LAY_LINECLR;
         3'b110:  layout_o = LAY_WIDE;
         default: layout_o = LAY_STD;
      endcase
   end
endmodule

// File: rtl/vid_line_split.sv
module vid_line_split
   import vid_addr_pkg::*;
#(
   parameter int LINE_W  = 8,
   parameter int BYTE_W  = 5,
   parameter int N_LINES = 192,
   localparam int OFF_W  = LINE_W + BYTE_W
) (
   input  logic [LINE_W-1:0] line_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [OFF_W-1:0]  pix_off_o,
   output logic [OFF_W-1:0]  lin_off_o,
   output logic              in_range_o
);
   line_fields_t lf;

   assign lf         = line_fields_t'(line_i);
   assign pix_off_o  = {lf.third, lf.sub, lf.row, byte_i};
   assign lin_off_o  = {3'b000, lf.third, lf.row, byte_i};
   assign in_range_o = (int'(line_i) < N_LINES);
endmodule

// File: rtl/vid_addr_mux.sv
module vid_addr_mux
   import vid_addr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 13
) (
   input  layout_e           layout_i,
   input  logic              kind_i,
   input  logic              wide_hi_i,
   input  logic [OFF_W-1:0]  pix_off_i,
   input  logic [OFF_W-1:0]  lin_off_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              no_clr_o
);
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] pix_ext;
   logic [ADDR_W-1:0] lin_ext;

   assign pix_ext = ADDR_W'(pix_off_i);
   assign lin_ext = ADDR_W'(lin_off_i);

   always_comb begin
      unique case (layout_i)
         LAY_ALT:  base = ADDR_W'(BUF_HI_BASE);
         LAY_WIDE: base = wide_hi_i ? ADDR_W'(BUF_HI_BASE) : ADDR_W'(BUF_LO_BASE);
         default:  base = ADDR_W'(BUF_LO_BASE);
      endcase
   end

   always_comb begin
      no_clr_o = (layout_i == LAY_WIDE);
      if (!kind_i)
         addr_o = base + pix_ext;
      else if (layout_i == LAY_LINECLR)
         addr_o = ADDR_W'(BUF_HI_BASE) + pix_ext;
      else
         addr_o = base + ADDR_W'(CLR_TBL_OFF) + lin_ext;
   end
endmodule

// File: rtl/vid_addr_gen.sv
module vid_addr_gen
   import vid_addr_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int LINE_W  = 8,
   parameter int COL_W   = 6,
   parameter int MODE_W  = 3,
   parameter int N_LINES = 192,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] line_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              kind_i,
   input  logic              req_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              fetch_o,
   output logic              oor_o
);
   localparam int BYTE_W = COL_W - 1;
   localparam int OFF_W  = LINE_W + BYTE_W;

   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("vid_addr_gen: ADDR_W must be at least 16");
      end
      if (LINE_W != 8 || COL_W != 6 || MODE_W != 3) begin : g_bad_geom
         $error("vid_addr_gen: line/column/mode widths are fixed at 8/6/3");
      end
      if (N_LINES > (1 << LINE_W)) begin : g_bad_lines
         $error("vid_addr_gen: N_LINES exceeds line range");
      end
   endgenerate

   layout_e            layout;
   logic [BYTE_W-1:0]  byte_sel;
   logic [OFF_W-1:0]   pix_off;
   logic [OFF_W-1:0]   lin_off;
   logic               in_range;
   logic [ADDR_W-1:0]  addr_c;
   logic               no_clr;
   logic               fetch_c;

   vid_mode_dec #(.MODE_W(MODE_W)) u_dec (
      .mode_i   (mode_i),
      .layout_o (layout)
   );

   assign byte_sel = (layout == LAY_WIDE) ? col_i[COL_W-1:1] : col_i[BYTE_W-1:0];

   vid_line_split #(.LINE_W(LINE_W), .BYTE_W(BYTE_W), .N_LINES(N_LINES)) u_split (
      .line_i     (line_i),
      .byte_i     (byte_sel),
      .pix_off_o  (pix_off),
      .lin_off_o  (lin_off),
      .in_range_o (in_range)
   );

   vid_addr_mux #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_mux (
      .layout_i  (layout),
      .kind_i    (kind_i),
      .wide_hi_i (col_i[0]),
      .pix_off_i (pix_off),
      .lin_off_i (lin_off),
      .addr_o    (addr_c),
      .no_clr_o  (no_clr)
   );

   assign fetch_c = req_i && in_range && !(no_clr && kind_i);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_o  <= '0;
               fetch_o <= 1'b0;
               oor_o   <= 1'b0;
            end else begin
               addr_o  <= addr_c;
               fetch_o <= fetch_c;
               oor_o   <= !in_range;
            end
         end
      end else begin : g_comb
         assign addr_o  = addr_c;
         assign fetch_o = fetch_c;
         assign oor_o   = !in_range;
      end
   endgenerate
endmodule

// File: rtl/vid_addr_chk.sv
module vid_addr_chk #(
   parameter bit REG_OUT = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic [7:0]  line_i,
   input logic [5:0]  col_i,
   input logic [2:0]  mode_i,
   input logic        kind_i,
   input logic        req_i,
   input logic [15:0] addr_o,
   input logic        fetch_o,
   input logic        oor_o
);
   logic [7:0] l_s;
   logic [5:0] c_s;
   logic [2:0] m_s;
   logic       k_s;
   logic       r_s;
   logic       ok;

   generate
      if (REG_OUT) begin : g_lag
         logic warm;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) warm <= 1'b0;
            else        warm <= 1'b1;
         end
         always_ff @(posedge clk) begin
            l_s <= line_i;
            c_s <= col_i;
            m_s <= mode_i;
            k_s <= kind_i;
            r_s <= req_i;
         end
         assign ok = warm;
      end else begin : g_now
         assign l_s = line_i;
         assign c_s = col_i;
         assign m_s = mode_i;
         assign k_s = kind_i;
         assign r_s = req_i;
         assign ok  = 1'b1;
      end
   endgenerate

   a_r7_oor_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ok |-> (oor_o == (l_s >= 8'd192)));

   a_r7_oor_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      oor_o |-> !fetch_o);

   a_r6_wide_no_colour: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && m_s == 3'b110 && k_s) |-> !fetch_o);

   a_r9_no_req_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && !r_s) |-> !fetch_o);

   a_r1_low_pixel: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && fetch_o && !k_s && m_s == 3'b000) |->
      (addr_o[4:0] == c_s[4:0] && addr_o[15:13] == 3'b010));

   a_r3_alt_window: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && fetch_o && m_s == 3'b001) |-> (addr_o[15:13] == 3'b011));
endmodule

bind vid_addr_gen vid_addr_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .line_i  (line_i),
   .col_i   (col_i),
   .mode_i  (mode_i),
   .kind_i  (kind_i),
   .req_i   (req_i),
   .addr_o  (addr_o),
   .fetch_o (fetch_o),
   .oor_o   (oor_o)
);

// File: tb/vid_addr_gen_bench.sv
module vid_addr_gen_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   logic [7:0]  ln, ln_r;
   logic [5:0]  cl, cl_r;
   logic [2:0]  md, md_r;
   logic        kd, kd_r, rq, rq_r;
   logic [15:0] a_c, a_r;
   logic        f_c, f_r, o_c, o_r;

   vid_addr_gen #(.REG_OUT(1'b0)) u_vid_addr_gen (
      .clk(clk), .rst_n(rst_n), .line_i(ln), .col_i(cl), .mode_i(md),
      .kind_i(kd), .req_i(rq), .addr_o(a_c), .fetch_o(f_c), .oor_o(o_c));

   vid_addr_gen #(.REG_OUT(1'b1)) u_vid_addr_gen_reg (
      .clk(clk), .rst_n(rst_n), .line_i(ln_r), .col_i(cl_r), .mode_i(md_r),
      .kind_i(kd_r), .req_i(rq_r), .addr_o(a_r), .fetch_o(f_r), .oor_o(o_r));

   function automatic int model_addr(int l, int c, int m, int k);
      int th = l / 64;
      int rw = (l / 8) % 8;
      int sb = l % 8;
      int cc = c % 32;
      int base = 'h4000;
      int po;
      if (m == 6) begin
         base = (c % 2 == 1) ? 'h6000 : 'h4000;
         cc = c / 2;
      end else if (m == 1) begin
         base = 'h6000;
      end
      po = th * 2048 + sb * 256 + rw * 32 + cc;
      if (k == 0) return base + po;
      if (m == 2) return 'h6000 + po;
      return base + 'h1800 + (l / 8) * 32 + cc;
   endfunction

   function automatic bit model_fetch(int l, int m, int k, int r);
      return (r == 1) && (l < 192) && !(m == 6 && k == 1);
   endfunction

   function automatic string req_of(int l, int m, int k);
      if (l >= 192) return "R7";
      if (m == 6) return (k == 1) ? "R6" : "R5";
      if (m == 1) return "R3";
      if (m == 2) return (k == 1) ? "R4" : "R1";
      if (m != 0) return "R8";
      return (k == 1) ? "R2" : "R1";
   endfunction

   task automatic check(bit cond, string rq_tag, int act, int exp);
      total++;
      if (!cond) begin
         bad++;
         if (bad < 20)
            $display("FAIL %s actual=%0h expected=%0h", rq_tag, act, exp);
      end
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      ln = 0; cl = 0; md = 0; kd = 0; rq = 0;
      ln_r = 0; cl_r = 0; md_r = 0; kd_r = 0; rq_r = 0;
      repeat (3) @(negedge clk);
      // R10: reset state of registered variant
      check(a_r == 16'h0, "R10", a_r, 0);
      check(f_r == 1'b0 && o_r == 1'b0, "R10", {f_r, o_r}, 0);
      rst_n = 1'b1;

      // Exhaustive sweep on the combinational variant (R1-R9)
      for (int m = 0; m < 8; m++) begin
         for (int l = 0; l < 200; l++) begin
            for (int c = 0; c < 64; c++) begin
               for (int k = 0; k < 2; k++) begin
                  int r = ((l + c + k) % 7 == 0) ? 0 : 1;
                  int ea;
                  bit ef;
                  ln = 8'(l); cl = 6'(c); md = 3'(m); kd = k[0]; rq = r[0];
                  #1;
                  ea = model_addr(l, c, m, k);
                  ef = model_fetch(l, m, k, r);
                  check(f_c == ef, (r == 0) ? "R9" : req_of(l, m, k), f_c, ef);
                  check(o_c == (l >= 192), "R7", o_c, (l >= 192));
                  if (l < 192 && !(m == 6 && k == 1))
                     check(int'(a_c) == ea, req_of(l, m, k), a_c, ea);
               end
            end
         end
      end

      // R10: registered variant shows previous-edge inputs
      for (int i = 0; i < 40; i++) begin
         int l = (i * 37) % 200;
         int c = (i * 11) % 64;
         int m = i % 8;
         int k = (i / 8) % 2;
         int ea = model_addr(l, c, m, k);
         bit ef = model_fetch(l, m, k, 1);
         @(negedge clk);
         ln_r = 8'(l); cl_r = 6'(c); md_r = 3'(m); kd_r = k[0]; rq_r = 1'b1;
         @(posedge clk);
         #1;
         check(f_r == ef, "R10", f_r, ef);
         check(o_r == (l >= 192), "R10", o_r, (l >= 192));
         if (ef) check(int'(a_r) == ea, "R10", a_r, ea);
      end
      // R10: output holds until the next edge
      @(negedge clk);
      ln_r = 8'd8; cl_r = 6'd0; md_r = 3'd0; kd_r = 1'b0; rq_r = 1'b1;
      @(posedge clk);
      #1;
      @(negedge clk);
      ln_r = 8'd1; cl_r = 6'd0;
      #1;
      check(a_r == 16'h4020, "R10", a_r, 16'h4020);
      @(posedge clk);
      #1;
      check(a_r == 16'h4100, "R10", a_r, 16'h4100);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule